// File: doc/BRIEF.md
# Video Memory DMA Sequencer

This block steps a video-memory DMA one access slot at a time. Each step turns into a write entry for the delayed write queue that sits in front of video memory. The top two bits of the source-high register pick one of three modes:

- **External transfer:** words are pulled from the external bus.
- **Fill:** the value last written to the data port is repeated.
- **Copy:** data is read back from the same video memory that the command code targets.

Host writes that arrive through the data port are turned into entries by the same logic. The two entry sources therefore share one address counter and one output.

A step may happen only on a slot strobe. No step happens when the queue is full or when the current slot is reserved for memory refresh. After each step the block advances the source, the destination address and the remaining length. When the length runs out, the DMA stops and clears the DMA request bits of the command code.

Top module: `vram_dma_seq`

## Requirements
- R1: `reg_sel` picks the register written by `reg_we`: 0 source low, 1 source mid, 2 source high, 3 length low, 4 length high, 5 address step. A command write loads the code and the address. If code bit 5 is set and source-high bits 7:6 are not `10`, `busy` rises on the next cycle. In fill mode (`10`) the command alone leaves `busy` low.
- R2: No DMA step happens on a strobe while `fifo_full` is high. A data port write is also refused while `fifo_full` is high.
- R3: A strobe is a refresh slot, and so produces no DMA step, in these cases:
  - `wide_mode` is 1 and the slot is 37, 69, 102, 133, 165, 197 or any slot of 210 or more.
  - `wide_mode` is 0 and the slot is 24, 56, 88, 120 or 152.
- R4: Source-high bit 7 = 0 selects an external transfer.
  - It reads `ext_addr` = {source high, source mid, source low}.
  - It queues `ext_data` with the partial flag 0.
  - It skips the step when the previous strobe fell on a refresh slot.
- R5: Source-high bits 7:6 = `11` select a copy.
  - The copy steps only when the previous strobe had `slot_unused` high.
  - Code 1 reads memory select 0 at {mid, low}. Code 3 reads select 1 at low mod 64. Code 5 reads select 2 at low mod 64.
  - A scroll source index of 40 or more queues 0.
- R6: A fill step queues the last value written to the data port, with the partial flag 1. When the code target is 1 (pattern memory), only the high byte of that value is used, placed in bits 7:0.
- R7: After each DMA step:
  - source low increments, carrying only into source mid (source high is unchanged);
  - the address adds the step register;
  - the 16-bit length decrements.
- R8: When the length reaches 0, `busy` falls and code bits 5:4 are cleared.
- R9: A data port write is accepted only when code bit 0 is 1 and the DMA is idle or in fill mode. An accepted write:
  - queues the written value at the current address, with partial flag 0;
  - adds the step to the address;
  - in fill mode with code bit 5 set, arms the fill by raising `busy`.
- R10: After reset, `busy`, `ent_valid`, `cur_code`, `cur_addr` and `len_left` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 6 | Command code (target, DMA request) |
| cmd_addr | input | AW | Command destination address |
| dp_we | input | 1 | Data port write request |
| dp_data | input | DW | Data port write value |
| dp_accept | output | 1 | Data port write taken this cycle |
| slot_stb | input | 1 | Access slot strobe |
| slot_num | input | 8 | Slot number within the line |
| slot_unused | input | 1 | This slot's queue access went unused |
| wide_mode | input | 1 | Wide line timing |
| fifo_full | input | 1 | Write queue has no room |
| ext_rd | output | 1 | External bus read this cycle |
| ext_addr | output | 24 | External source address |
| ext_data | input | DW | External read data, same cycle |
| mem_rd | output | 1 | Internal memory read this cycle |
| mem_sel | output | 2 | Internal memory select |
| mem_addr | output | AW | Internal memory read index |
| mem_data | input | DW | Internal read data, same cycle |
| ent_valid | output | 1 | Queue entry valid |
| ent_addr | output | AW | Entry address |
| ent_data | output | DW | Entry value |
| ent_code | output | 6 | Entry code |
| ent_partial | output | 1 | Entry partial flag |
| busy | output | 1 | DMA running |
| cur_code | output | 6 | Current code register |
| cur_addr | output | AW | Current destination address |
| len_left | output | 16 | Remaining length |

## Verification
The assertions take two things for granted about the inputs:

- The command port is never written while a DMA is running, so `busy` falls only when the length runs out.
- Read data on the external and internal ports is valid in the same cycle as the read strobe.

The stimulus follows both rules. It issues commands only while `busy` is low. Its memory models are pure combinational functions of the read address and select. Strobes, data port writes and register writes are never driven in the same cycle.

// File: rtl/vram_dma_seq.sv
module vram_dma_seq #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int CRAM_DEPTH  = 64,
  parameter int VSRAM_DEPTH = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          cmd_we,
  input  logic [5:0]    cmd_code,
  input  logic [AW-1:0] cmd_addr,
  input  logic          dp_we,
  input  logic [DW-1:0] dp_data,
  output logic          dp_accept,
  input  logic          slot_stb,
  input  logic [7:0]    slot_num,
  input  logic          slot_unused,
  input  logic          wide_mode,
  input  logic          fifo_full,
  output logic          ext_rd,
  output logic [23:0]   ext_addr,
  input  logic [DW-1:0] ext_data,
  output logic          mem_rd,
  output logic [1:0]    mem_sel,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  output logic          ent_valid,
  output logic [AW-1:0] ent_addr,
  output logic [DW-1:0] ent_data,
  output logic [5:0]    ent_code,
  output logic          ent_partial,
  output logic          busy,
  output logic [5:0]    cur_code,
  output logic [AW-1:0] cur_addr,
  output logic [15:0]   len_left
);
  localparam logic [AW-1:0] CRAM_MASK = AW'(CRAM_DEPTH - 1);
  localparam logic [3:0] T_VRAM = 4'h1, T_CRAM = 4'h3, T_VSRAM = 4'h5;

  logic [7:0]    src_hi, src_mid, src_lo, step_q;
  logic [15:0]   len_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] last_q;
  logic [5:0]    code_q;
  logic          busy_q, prev_ref_q, idle_q;
  logic          is_ref, vs_oor, act, copy_go, fill_go, run;
  logic [DW-1:0] run_val;
  logic [15:0]   len_nx;

  wire is_ext  = ~src_hi[7];
  wire is_fill = src_hi[7:6] == 2'b10;
  wire is_copy = src_hi[7:6] == 2'b11;
  wire [3:0] tgt = code_q[3:0];

  always_comb begin
    if (wide_mode)
      is_ref = slot_num == 8'd37  || slot_num == 8'd69  || slot_num == 8'd102 ||
               slot_num == 8'd133 || slot_num == 8'd165 || slot_num == 8'd197 ||
               slot_num >= 8'd210;
    else
      is_ref = slot_num == 8'd24 || slot_num == 8'd56 || slot_num == 8'd88 ||
               slot_num == 8'd120 || slot_num == 8'd152;
  end

  assign dp_accept = dp_we && code_q[0] && !fifo_full && (!busy_q || is_fill);
  assign act       = slot_stb && busy_q && !is_ref && !fifo_full && !dp_accept;
  assign vs_oor    = (tgt == T_VSRAM) && (32'(src_lo[5:0]) >= VSRAM_DEPTH);
  assign ext_rd    = act && is_ext && !prev_ref_q;
  assign copy_go   = act && is_copy && idle_q;
  assign fill_go   = act && is_fill;
  assign mem_rd    = copy_go && !vs_oor;
  assign run       = ext_rd || copy_go || fill_go;
  assign ext_addr  = {src_hi, src_mid, src_lo};
  assign len_nx    = len_q - 16'd1;

  always_comb begin
    mem_sel  = 2'd0;
    mem_addr = AW'({src_mid, src_lo});
    if (tgt == T_CRAM) begin
      mem_sel  = 2'd1;
      mem_addr = AW'(src_lo) & CRAM_MASK;
    end else if (tgt == T_VSRAM) begin
      mem_sel  = 2'd2;
      mem_addr = AW'(src_lo[5:0]);
    end
  end

  always_comb begin
    if (is_ext)       run_val = ext_data;
    else if (is_copy) run_val = vs_oor ? '0 : mem_data;
    else if (tgt == T_VRAM) run_val = DW'(last_q[DW-1:DW-8]);
    else              run_val = last_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi <= '0; src_mid <= '0; src_lo <= '0; step_q <= '0;
      len_q <= '0; addr_q <= '0; last_q <= '0; code_q <= '0;
      busy_q <= 1'b0; prev_ref_q <= 1'b0; idle_q <= 1'b0;
      ent_valid <= 1'b0; ent_addr <= '0; ent_data <= '0;
      ent_code <= '0; ent_partial <= 1'b0;
    end else begin
      ent_valid <= 1'b0;
      if (slot_stb) begin
        prev_ref_q <= is_ref;
        idle_q     <= slot_unused;
      end
      if (reg_we) begin
        case (reg_sel)
          3'd0: src_lo  <= reg_wdata;
          3'd1: src_mid <= reg_wdata;
          3'd2: src_hi  <= reg_wdata;
          3'd3: len_q[7:0]  <= reg_wdata;
          3'd4: len_q[15:8] <= reg_wdata;
          3'd5: step_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (cmd_we) begin
        code_q <= cmd_code;
        addr_q <= cmd_addr;
        busy_q <= cmd_code[5] && !is_fill;
      end
      if (dp_accept) begin
        ent_valid   <= 1'b1;
        ent_addr    <= addr_q;
        ent_data    <= dp_data;
        ent_code    <= code_q;
        ent_partial <= 1'b0;
        addr_q      <= addr_q + AW'(step_q);
        last_q      <= dp_data;
        if (code_q[5] && is_fill) busy_q <= 1'b1;
      end else if (run) begin
        ent_valid   <= 1'b1;
        ent_addr    <= addr_q;
        ent_data    <= run_val;
        ent_code    <= code_q;
        ent_partial <= fill_go;
        addr_q      <= addr_q + AW'(step_q);
        src_lo      <= src_lo + 8'd1;
        if (src_lo == 8'hFF) src_mid <= src_mid + 8'd1;
        len_q       <= len_nx;
        if (len_nx == 16'd0) begin
          busy_q <= 1'b0;
          code_q <= {2'b00, code_q[3:0]};
        end
      end
    end
  end

  assign busy     = busy_q;
  assign cur_code = code_q;
  assign cur_addr = addr_q;
  assign len_left = len_q;
endmodule

// File: rtl/vram_dma_seq_chk.sv
module vram_dma_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_full,
  input logic        slot_stb,
  input logic [7:0]  slot_num,
  input logic        wide_mode,
  input logic        dp_we,
  input logic        ext_rd,
  input logic        ent_valid,
  input logic        ent_partial,
  input logic        busy,
  input logic [5:0]  cur_code,
  input logic [15:0] len_left
);
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !ent_valid);

  p_ext_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |-> (slot_stb && !fifo_full && busy));

  p_refresh_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && wide_mode && slot_num >= 8'd210 && !dp_we) |=> !ent_valid);

  p_ext_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |=> (ent_valid && !ent_partial));

  p_stop_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cur_code[5:4] == 2'b00 && len_left == 16'd0));
endmodule

bind vram_dma_seq vram_dma_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full), .slot_stb(slot_stb),
  .slot_num(slot_num), .wide_mode(wide_mode), .dp_we(dp_we), .ext_rd(ext_rd),
  .ent_valid(ent_valid), .ent_partial(ent_partial), .busy(busy),
  .cur_code(cur_code), .len_left(len_left)
);

// File: tb/sim_vram_dma_seq.sv
module sim_vram_dma_seq;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_sel = 0; logic [7:0] reg_wdata = 0;
  logic cmd_we = 0; logic [5:0] cmd_code = 0; logic [15:0] cmd_addr = 0;
  logic dp_we = 0; logic [15:0] dp_data = 0; logic dp_accept;
  logic slot_stb = 0; logic [7:0] slot_num = 0; logic slot_unused = 0;
  logic wide_mode = 1; logic fifo_full = 0;
  logic ext_rd; logic [23:0] ext_addr; logic [15:0] ext_data;
  logic mem_rd; logic [1:0] mem_sel; logic [15:0] mem_addr; logic [15:0] mem_data;
  logic ent_valid; logic [15:0] ent_addr, ent_data; logic [5:0] ent_code; logic ent_partial;
  logic busy; logic [5:0] cur_code; logic [15:0] cur_addr, len_left;

  int checks = 0, errors = 0;
  bit done = 0;
  logic rd_seen, mrd_seen, acc;
  logic [23:0] ea_seen;
  logic [15:0] md_seen;

  assign ext_data = ext_addr[15:0] ^ 16'hA5A5;
  assign mem_data = {mem_sel, 4'h0, mem_addr[9:0]};

  always #(CLK_P/2) clk = ~clk;

  vram_dma_seq u0 (.*);

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, a, e);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic cmd(input logic [5:0] c, input logic [15:0] a);
    cmd_we = 1; cmd_code = c; cmd_addr = a;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic dpw(input logic [15:0] d, input logic ff);
    dp_we = 1; dp_data = d; fifo_full = ff;
    #1 acc = dp_accept;
    @(negedge clk); dp_we = 0; fifo_full = 0;
  endtask

  task automatic slot(input logic [7:0] n, input logic un, input logic ff);
    slot_stb = 1; slot_num = n; slot_unused = un; fifo_full = ff;
    #1 rd_seen = ext_rd; mrd_seen = mem_rd; ea_seen = ext_addr; md_seen = mem_addr;
    @(negedge clk); slot_stb = 0; slot_unused = 0; fifo_full = 0;
  endtask

  // {wide, slot, refresh expected}
  localparam logic [9:0] TBL [13] = '{
    {1'b1, 8'd37, 1'b1}, {1'b1, 8'd38, 1'b0}, {1'b1, 8'd69, 1'b1},
    {1'b1, 8'd102, 1'b1}, {1'b1, 8'd209, 1'b0}, {1'b1, 8'd210, 1'b1},
    {1'b1, 8'd255, 1'b1}, {1'b0, 8'd24, 1'b1}, {1'b0, 8'd37, 1'b0},
    {1'b0, 8'd152, 1'b1}, {1'b0, 8'd210, 1'b0}, {1'b0, 8'd56, 1'b1},
    {1'b1, 8'd24, 1'b0}};

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0); chk("R10 valid", ent_valid, 0);
    chk("R10 code", cur_code, 0); chk("R10 addr", cur_addr, 0);
    chk("R10 len", len_left, 0);

    // external transfer
    wreg(5, 8'd2); wreg(0, 8'hFE); wreg(1, 8'h12); wreg(2, 8'h03);
    wreg(3, 8'd3); wreg(4, 8'd0);
    cmd(6'h21, 16'h1000);
    chk("R1 ext start", busy, 1);
    slot(8'd10, 0, 0);
    chk("R4 read addr", ea_seen, 24'h0312FE);
    chk("R4 entry", {ent_valid, ent_partial, ent_addr}, {2'b10, 16'h1000});
    chk("R4 data", ent_data, 16'h12FE ^ 16'hA5A5);
    dpw(16'h7777, 0);
    chk("R9 reject busy", {acc, ent_valid, cur_addr}, {2'b00, 16'h1002});
    slot(8'd37, 0, 0);
    chk("R3 wide refresh", ent_valid, 0);
    slot(8'd38, 0, 0);
    chk("R4 after refresh", {rd_seen, ent_valid}, 2'b00);
    slot(8'd40, 0, 1);
    chk("R2 full", ent_valid, 0);
    slot(8'd41, 0, 0);
    chk("R7 src low", ea_seen, 24'h0312FF);
    chk("R7 addr step", {ent_valid, ent_addr}, {1'b1, 16'h1002});
    chk("R7 len", len_left, 1);
    slot(8'd42, 0, 0);
    chk("R7 carry mid only", ea_seen, 24'h031300);
    chk("R4 data3", ent_data, 16'h1300 ^ 16'hA5A5);
    chk("R8 stop", {busy, cur_code, len_left}, {1'b0, 6'h01, 16'd0});
    chk("R7 final addr", cur_addr, 16'h1006);

    // copy, color target
    wreg(5, 8'd1); wreg(2, 8'hC0); wreg(1, 8'h00); wreg(0, 8'h05);
    wreg(3, 8'd2); wreg(4, 8'd0);
    cmd(6'h23, 16'h0010);
    chk("R1 copy start", busy, 1);
    slot(8'd50, 1, 0);
    chk("R5 no flag", ent_valid, 0);
    slot(8'd51, 0, 0);
    chk("R5 copy read", {mrd_seen, md_seen}, {1'b1, 16'h0005});
    chk("R5 copy entry", {ent_valid, ent_addr, ent_data}, {1'b1, 16'h0010, 16'h4005});
    slot(8'd52, 0, 0);
    chk("R5 flag consumed", ent_valid, 0);
    slot(8'd53, 1, 0);
    slot(8'd54, 0, 0);
    chk("R5 copy2", {ent_valid, ent_data}, {1'b1, 16'h4006});
    chk("R8 copy end", {busy, cur_code}, {1'b0, 6'h03});

    // copy, scroll target, out of range
    wreg(0, 8'd45); wreg(3, 8'd1);
    cmd(6'h25, 16'h0040);
    slot(8'd60, 1, 0);
    slot(8'd61, 0, 0);
    chk("R5 oor zero", {ent_valid, ent_data}, {1'b1, 16'h0000});
    chk("R8 vs end", busy, 0);

    // fill, pattern target
    wreg(2, 8'h80); wreg(3, 8'd2); wreg(4, 8'd0);
    cmd(6'h21, 16'h2000);
    chk("R1 fill waits", busy, 0);
    dpw(16'hBEEF, 0);
    chk("R9 fill arm", {acc, busy, ent_valid, ent_partial, ent_data}, {4'b1110, 16'hBEEF});
    slot(8'd70, 0, 0);
    chk("R6 high byte", {ent_valid, ent_partial, ent_addr, ent_data}, {2'b11, 16'h2001, 16'h00BE});
    dpw(16'h1234, 0);
    chk("R9 fill rearm", {acc, busy, ent_addr}, {2'b11, 16'h2002});
    slot(8'd71, 0, 0);
    chk("R6 new value", {ent_valid, ent_data, ent_addr}, {1'b1, 16'h0012, 16'h2003});
    chk("R8 fill end", {busy, cur_code}, {1'b0, 6'h01});

    // fill, color target, refresh table
    wreg(3, 8'h00); wreg(4, 8'h01);
    cmd(6'h23, 16'h0000);
    dpw(16'h5A5A, 0);
    for (int i = 0; i < 13; i++) begin
      wide_mode = TBL[i][9];
      slot(TBL[i][8:1], 0, 0);
      chk($sformatf("R3 slot %0d wide %0d", TBL[i][8:1], TBL[i][9]), ent_valid, !TBL[i][0]);
      if (!TBL[i][0]) chk("R6 full word", {ent_partial, ent_data}, {1'b1, 16'h5A5A});
    end
    wide_mode = 1;

    // reset and port rejection
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R10 reset again", {busy, cur_code, len_left}, 23'd0);
    dpw(16'h0101, 0);
    chk("R9 read code", {acc, ent_valid}, 2'b00);
    cmd(6'h01, 16'h0300);
    dpw(16'h0202, 1);
    chk("R2 full port", {acc, ent_valid}, 2'b00);
    dpw(16'h0303, 0);
    chk("R9 plain write", {acc, ent_valid, ent_partial, ent_addr, ent_data}, {3'b110, 16'h0300, 16'h0303});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule